// File: doc/BRIEF.md
# Multi-Mode Program Bank Mapper

This block sits between an 8-bit CPU and its program memories. It turns a 16-bit CPU address in the upper 40 KB of the map into either a 20-bit program ROM address or a work-RAM address with a chip select. It also produces the enables and a guarded RAM write enable. The translation depends on a 2-bit layout mode. The mode splits `$8000-$FFFF` into one, two, three or four windows. All four layouts share one file of four window bank registers. A fifth register maps the fixed 8 KB RAM window at `$6000-$7FFF`.

Software programs the block through the CPU bus itself. A write strobe to an address in `$5100-$5117` updates a register at the next clock edge. The translation path is purely combinational from the CPU address and the stored registers. ROM and RAM can therefore sit directly on the same bus cycle. The middle windows can each be pointed at RAM instead of ROM. RAM stores are blocked unless two separate protect registers both hold their unlock codes.

Top module: `prg_bank_mapper`

## Requirements
- R1: After reset, the mode is 3 and window registers 0-2 hold `8'h80`, which is ROM bank 0. Window register 3 holds all ones, so `$E000-$FFFF` maps ROM bank `7'h7F`. The RAM bank register and both protect registers hold zero.
- R2: A CPU write (`cpu_we_i`=1) takes effect at the rising clock edge, and only at these exact addresses:
  - `$5100`: mode, bits 1:0.
  - `$5102`: protect A, bits 1:0.
  - `$5103`: protect B, bits 1:0.
  - `$5113`: RAM bank register, bits 2:0.
  - `$5114` to `$5117`: window registers 0 to 3.
  All other addresses, and cycles with the strobe low, leave the mapping unchanged.
- R3: `$6000-$7FFF` always selects RAM. Bit 2 of the RAM bank register is `ram_chip_o`, and bits 1:0 of that register are RAM address bits 14:13.
- R4: Mode 0 maps `$8000-$FFFF` as one 32 KB ROM window from window register 3. Its bits 6:2 become ROM bank bits 6:2, and CPU address bits 14:13 fill bank bits 1:0.
- R5: Mode 1 has two 16 KB windows. `$8000-$BFFF` uses window register 1 and `$C000-$FFFF` uses window register 3. In both, bank bit 0 comes from CPU address bit 13.
- R6: Mode 2 has three windows:
  - `$8000-$BFFF`: 16 KB from window register 1, bank bit 0 from CPU address bit 13.
  - `$C000-$DFFF`: 8 KB from window register 2.
  - `$E000-$FFFF`: 8 KB from window register 3.
- R7: Mode 3 has four 8 KB windows, selected by CPU address bits 14:13 from window registers 0 to 3.
- R8: In window registers 0-2, bit 7 selects ROM (1) or RAM (0). On a RAM selection, effective bank bits 1:0 become RAM address bits 14:13 and effective bank bit 2 is the chip select. Window register 3 always maps ROM, whatever its bit 7 holds.
- R9: `ram_we_o` is high only when all of the following hold:
  - `cpu_we_i` is high;
  - the address falls in a RAM-mapped window;
  - protect A bits 1:0 equal `2'b10`;
  - protect B bits 1:0 equal `2'b01`.
- R10: A CPU write to a ROM-mapped window never raises `ram_we_o`, even when unlocked.
- R11: Addresses below `$6000` raise neither `rom_en_o` nor `ram_en_o`.
- R12: A ROM access drives `rom_addr_o` as the 7-bit effective bank followed by CPU address bits 12:0. A RAM access carries CPU address bits 12:0 in the low bits of `ram_addr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_addr_i | input | 16 | CPU address |
| cpu_data_i | input | 8 | CPU write data, used for register writes |
| cpu_we_i | input | 1 | CPU write strobe |
| rom_addr_o | output | 20 | Program ROM byte address |
| ram_addr_o | output | 15 | Work-RAM byte address within one chip |
| ram_chip_o | output | 1 | Work-RAM chip select (0 or 1) |
| rom_en_o | output | 1 | ROM access enable |
| ram_en_o | output | 1 | RAM access enable |
| ram_we_o | output | 1 | Guarded RAM write enable |

## Verification
The bench builds the mapper with its defaults:
- 8-bit registers, so ROM banks are 7 bits wide;
- 8 KB pages;
- a 2-bit RAM bank within a chip.

With these values, every effective bank bit is visible on `rom_addr_o`, `ram_addr_o` and `ram_chip_o`. Each mode can be checked with patterns whose ignored low bits are set, which exposes any failure to substitute the CPU address bits. The full 4x4 space of the two protect fields can be swept at small cost. Upper protect bits can be loaded with junk to show that only bits 1:0 count.

// File: rtl/prg_map_pkg.sv
`timescale 1ns/1ps
package prg_map_pkg;

  typedef enum logic [1:0] {
    MODE_32K = 2'd0,
    MODE_16K = 2'd1,
    MODE_MIX = 2'd2,
    MODE_8K  = 2'd3
  } prg_mode_e;

  // register page high byte and offsets within it
  localparam logic [7:0] REG_PAGE   = 8'h51;
  localparam logic [7:0] REG_LAST   = 8'h17;
  localparam logic [4:0] OFF_MODE   = 5'h00;
  localparam logic [4:0] OFF_PROT_A = 5'h02;
  localparam logic [4:0] OFF_PROT_B = 5'h03;
  localparam logic [4:0] OFF_RAM    = 5'h13;
  localparam logic [4:0] OFF_WIN0   = 5'h14;

  localparam logic [1:0] PROT_A_KEY = 2'b10;
  localparam logic [1:0] PROT_B_KEY = 2'b01;

endpackage

// File: rtl/prg_reg_file.sv
`timescale 1ns/1ps
module prg_reg_file
  import prg_map_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int WIN_N     = 4,
  parameter int RAM_SEL_W = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [4:0]                    wr_off_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  output prg_mode_e                     mode_o,
  output logic [1:0]                    prot_a_o,
  output logic [1:0]                    prot_b_o,
  output logic [RAM_SEL_W-1:0]          ram_bank_o,
  output logic [WIN_N-1:0][DATA_W-1:0]  win_o
);

  prg_mode_e             mode_q;
  logic [1:0]            prot_a_q, prot_b_q;
  logic [RAM_SEL_W-1:0]  ram_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_8K;
      prot_a_q <= '0;
      prot_b_q <= '0;
      ram_q    <= '0;
    end else if (wr_en_i) begin
      if (wr_off_i == OFF_MODE)   mode_q   <= prg_mode_e'(wr_data_i[1:0]);
      if (wr_off_i == OFF_PROT_A) prot_a_q <= wr_data_i[1:0];
      if (wr_off_i == OFF_PROT_B) prot_b_q <= wr_data_i[1:0];
      if (wr_off_i == OFF_RAM)    ram_q    <= wr_data_i[RAM_SEL_W-1:0];
    end
  end

  for (genvar i = 0; i < WIN_N; i++) begin : g_win
    localparam logic [4:0]        OFF = OFF_WIN0 + 5'(i);
    // top window boots into the last ROM bank, others into ROM bank 0
    localparam logic [DATA_W-1:0] RST = (i == WIN_N-1) ? {DATA_W{1'b1}}
                                                       : {1'b1, {(DATA_W-1){1'b0}}};
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          q <= RST;
      else if (wr_en_i && wr_off_i == OFF)  q <= wr_data_i;
    end
    assign win_o[i] = q;
  end

  assign mode_o     = mode_q;
  assign prot_a_o   = prot_a_q;
  assign prot_b_o   = prot_b_q;
  assign ram_bank_o = ram_q;

endmodule

// File: rtl/prg_window_decode.sv
`timescale 1ns/1ps
module prg_window_decode
  import prg_map_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int RAM_SEL_W = 3,
  localparam int BANK_W   = DATA_W - 1,
  localparam int WIN_N    = 4
) (
  input  prg_mode_e                     mode_i,
  input  logic [2:0]                    region_i,   // CPU address bits 15:13
  input  logic [WIN_N-1:0][DATA_W-1:0]  win_i,
  input  logic [RAM_SEL_W-1:0]          ram_bank_i,
  output logic                          hit_rom_o,
  output logic                          hit_ram_o,
  output logic [BANK_W-1:0]             bank_o
);

  logic [1:0]        slot;
  logic              in_ram_win, in_prg;
  logic [1:0]        sel;
  logic [1:0]        keep;       // low bank bits taken from the address
  logic [DATA_W-1:0] raw;
  logic [BANK_W-1:0] win_bank;
  logic              win_is_rom;

  assign slot       = region_i[1:0];
  assign in_prg     = region_i[2];
  assign in_ram_win = (region_i == 3'b011);

  always_comb begin
    sel  = slot;
    keep = 2'd0;
    unique case (mode_i)
      MODE_32K: begin sel = 2'd3; keep = 2'd2; end
      MODE_16K: begin sel = slot[1] ? 2'd3 : 2'd1; keep = 2'd1; end
      MODE_MIX: begin
        if (!slot[1]) begin sel = 2'd1; keep = 2'd1; end
        else          begin sel = slot; keep = 2'd0; end
      end
      default:  begin sel = slot; keep = 2'd0; end
    endcase

    raw = win_i[sel];
    unique case (keep)
      2'd2:    win_bank = {raw[BANK_W-1:2], slot};
      2'd1:    win_bank = {raw[BANK_W-1:1], slot[0]};
      default: win_bank = raw[BANK_W-1:0];
    endcase
    // last window register is ROM only
    win_is_rom = (sel == 2'd3) || raw[DATA_W-1];
  end

  assign hit_rom_o = in_prg && win_is_rom;
  assign hit_ram_o = in_ram_win || (in_prg && !win_is_rom);
  assign bank_o    = in_ram_win ? BANK_W'(ram_bank_i) : win_bank;

endmodule

// File: rtl/prg_write_guard.sv
`timescale 1ns/1ps
module prg_write_guard
  import prg_map_pkg::*;
(
  input  logic [1:0] prot_a_i,
  input  logic [1:0] prot_b_i,
  input  logic       cpu_we_i,
  input  logic       hit_ram_i,
  output logic       ram_we_o
);

  logic unlocked;

  assign unlocked = (prot_a_i == PROT_A_KEY) && (prot_b_i == PROT_B_KEY);
  assign ram_we_o = cpu_we_i && hit_ram_i && unlocked;

endmodule

// File: rtl/prg_bank_mapper.sv
`timescale 1ns/1ps
module prg_bank_mapper
  import prg_map_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int PAGE_W     = 13,
  parameter int RAM_BANK_W = 2,
  localparam int ADDR_W    = 16,
  localparam int WIN_N     = 4,
  localparam int BANK_W    = DATA_W - 1,
  localparam int RAM_SEL_W = RAM_BANK_W + 1,
  localparam int ROM_AW    = BANK_W + PAGE_W,
  localparam int RAM_AW    = RAM_BANK_W + PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_data_i,
  input  logic              cpu_we_i,
  output logic [ROM_AW-1:0] rom_addr_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic              ram_chip_o,
  output logic              rom_en_o,
  output logic              ram_en_o,
  output logic              ram_we_o
);

  prg_mode_e                    mode;
  logic [1:0]                   prot_a, prot_b;
  logic [RAM_SEL_W-1:0]         ram_bank;
  logic [WIN_N-1:0][DATA_W-1:0] win;
  logic                         reg_wr;
  logic                         hit_rom, hit_ram;
  logic [BANK_W-1:0]            bank;

  assign reg_wr = cpu_we_i && (cpu_addr_i[ADDR_W-1:8] == REG_PAGE)
                           && (cpu_addr_i[7:0] <= REG_LAST);

  prg_reg_file #(
    .DATA_W    (DATA_W),
    .WIN_N     (WIN_N),
    .RAM_SEL_W (RAM_SEL_W)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (reg_wr),
    .wr_off_i   (cpu_addr_i[4:0]),
    .wr_data_i  (cpu_data_i),
    .mode_o     (mode),
    .prot_a_o   (prot_a),
    .prot_b_o   (prot_b),
    .ram_bank_o (ram_bank),
    .win_o      (win)
  );

  prg_window_decode #(
    .DATA_W    (DATA_W),
    .RAM_SEL_W (RAM_SEL_W)
  ) u_dec (
    .mode_i     (mode),
    .region_i   (cpu_addr_i[ADDR_W-1:PAGE_W]),
    .win_i      (win),
    .ram_bank_i (ram_bank),
    .hit_rom_o  (hit_rom),
    .hit_ram_o  (hit_ram),
    .bank_o     (bank)
  );

  prg_write_guard u_guard (
    .prot_a_i  (prot_a),
    .prot_b_i  (prot_b),
    .cpu_we_i  (cpu_we_i),
    .hit_ram_i (hit_ram),
    .ram_we_o  (ram_we_o)
  );

  assign rom_addr_o = {bank, cpu_addr_i[PAGE_W-1:0]};
  assign ram_addr_o = {bank[RAM_BANK_W-1:0], cpu_addr_i[PAGE_W-1:0]};
  assign ram_chip_o = bank[RAM_BANK_W];
  assign rom_en_o   = hit_rom;
  assign ram_en_o   = hit_ram;

endmodule

// File: rtl/prg_bank_mapper_chk.sv
`timescale 1ns/1ps
module prg_bank_mapper_chk #(
  parameter int PAGE_W = 13,
  parameter int ROM_AW = 20,
  parameter int RAM_AW = 15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [15:0]       cpu_addr_i,
  input logic              cpu_we_i,
  input logic [ROM_AW-1:0] rom_addr_o,
  input logic [RAM_AW-1:0] ram_addr_o,
  input logic              rom_en_o,
  input logic              ram_en_o,
  input logic              ram_we_o
);

  p_one_target_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rom_en_o && ram_en_o));

  p_low_space_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_addr_i[15:13] < 3'd3) |-> (!rom_en_o && !ram_en_o));

  p_ram_window_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_addr_i[15:13] == 3'b011) |-> (ram_en_o && !rom_en_o));

  p_rom_offset_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_en_o |-> (rom_addr_o[PAGE_W-1:0] == cpu_addr_i[PAGE_W-1:0]));

  p_ram_offset_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_en_o |-> (ram_addr_o[PAGE_W-1:0] == cpu_addr_i[PAGE_W-1:0]));

  p_we_target_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (ram_en_o && cpu_we_i && !rom_en_o));

endmodule

bind prg_bank_mapper prg_bank_mapper_chk #(
  .PAGE_W (PAGE_W),
  .ROM_AW (ROM_AW),
  .RAM_AW (RAM_AW)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cpu_addr_i (cpu_addr_i),
  .cpu_we_i   (cpu_we_i),
  .rom_addr_o (rom_addr_o),
  .ram_addr_o (ram_addr_o),
  .rom_en_o   (rom_en_o),
  .ram_en_o   (ram_en_o),
  .ram_we_o   (ram_we_o)
);

// File: tb/prg_bank_mapper_tb_top.sv
`timescale 1ns/1ps
module prg_bank_mapper_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        cpu_we = 1'b0;
  logic [19:0] rom_addr;
  logic [14:0] ram_addr;
  logic        ram_chip, rom_en, ram_en, ram_we;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // bench-side view of the programmed registers
  logic [1:0] m_mode = 2'd3;
  logic [1:0] m_pa = 2'd0, m_pb = 2'd0;
  logic [2:0] m_ram = 3'd0;
  logic [7:0] m_w [4] = '{8'h80, 8'h80, 8'h80, 8'hFF};

  always #2 clk = ~clk;

  prg_bank_mapper dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .cpu_addr_i (cpu_addr),
    .cpu_data_i (cpu_data),
    .cpu_we_i   (cpu_we),
    .rom_addr_o (rom_addr),
    .ram_addr_o (ram_addr),
    .ram_chip_o (ram_chip),
    .rom_en_o   (rom_en),
    .ram_en_o   (ram_en),
    .ram_we_o   (ram_we)
  );

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_we = 1'b1;
    @(posedge clk);
    #1 cpu_we = 1'b0;
    case (a)
      16'h5100: m_mode = d[1:0];
      16'h5102: m_pa   = d[1:0];
      16'h5103: m_pb   = d[1:0];
      16'h5113: m_ram  = d[2:0];
      16'h5114: m_w[0] = d;
      16'h5115: m_w[1] = d;
      16'h5116: m_w[2] = d;
      16'h5117: m_w[3] = d;
      default: ;
    endcase
  endtask

  // expected mapping from the requirements
  task automatic probe(input logic [15:0] a, input logic we, input string req);
    logic       e_rom, e_ram, e_we;
    logic [6:0] b;
    logic [7:0] r;
    logic [1:0] idx;
    e_rom = 1'b0; e_ram = 1'b0; b = '0;
    if (a >= 16'h8000) begin
      case (m_mode)
        2'd0: begin r = m_w[3]; b = {r[6:2], a[14:13]}; e_rom = 1'b1; end
        2'd1: begin
          r = a[14] ? m_w[3] : m_w[1];
          b = {r[6:1], a[13]}; e_rom = a[14] | r[7];
        end
        2'd2: begin
          if (!a[14])      begin r = m_w[1]; b = {r[6:1], a[13]}; e_rom = r[7]; end
          else if (!a[13]) begin r = m_w[2]; b = r[6:0]; e_rom = r[7]; end
          else             begin r = m_w[3]; b = r[6:0]; e_rom = 1'b1; end
        end
        default: begin
          idx = a[14:13]; r = m_w[idx]; b = r[6:0];
          e_rom = (idx == 2'd3) | r[7];
        end
      endcase
      e_ram = !e_rom;
    end else if (a >= 16'h6000) begin
      e_ram = 1'b1; b = {4'd0, m_ram};
    end
    e_we = we && e_ram && (m_pa == 2'b10) && (m_pb == 2'b01);

    @(negedge clk);
    cpu_addr = a; cpu_we = we; cpu_data = 8'h00;
    #1;
    n_chk++;
    if (rom_en !== e_rom || ram_en !== e_ram || ram_we !== e_we ||
        (e_rom && rom_addr !== {b, a[12:0]}) ||
        (e_ram && (ram_addr !== {b[1:0], a[12:0]} || ram_chip !== b[2]))) begin
      n_bad++;
      $display("FAIL %s addr=%h act rom_en=%b ram_en=%b we=%b rom=%h ram=%h chip=%b exp rom_en=%b ram_en=%b we=%b rom=%h ram=%h chip=%b",
               req, a, rom_en, ram_en, ram_we, rom_addr, ram_addr, ram_chip,
               e_rom, e_ram, e_we, {b, a[12:0]}, {b[1:0], a[12:0]}, b[2]);
    end
    cpu_we = 1'b0;
  endtask

  task automatic t_reset;
    probe(16'hE000, 1'b0, "R1");
    probe(16'hFFFF, 1'b0, "R1");
    probe(16'h8000, 1'b0, "R1");
    probe(16'hA010, 1'b0, "R1");
    probe(16'hC7FF, 1'b0, "R1");
    probe(16'h6000, 1'b1, "R1 locked");
    probe(16'h7FFF, 1'b0, "R1");
  endtask

  task automatic t_mode3;
    wr(16'h5114, 8'h81); wr(16'h5115, 8'hA2);
    wr(16'h5116, 8'hC3); wr(16'h5117, 8'h7C);
    probe(16'h8123, 1'b0, "R7 R12");
    probe(16'hA456, 1'b0, "R7 R12");
    probe(16'hC789, 1'b0, "R7 R12");
    probe(16'hFABC, 1'b0, "R7 R12");
  endtask

  task automatic t_decode;
    wr(16'h5101, 8'h00);    // neighbour of mode register
    wr(16'h5118, 8'h00);    // just past the window registers
    wr(16'h5104, 8'h00);
    wr(16'h5013, 8'h07);    // wrong page
    // strobe low at mode address over an edge
    @(negedge clk); cpu_addr = 16'h5100; cpu_data = 8'h00; cpu_we = 1'b0;
    @(posedge clk);
    probe(16'h8000, 1'b0, "R2 ignored");
    probe(16'hE000, 1'b0, "R2 ignored");
    probe(16'h6123, 1'b0, "R2 ignored");
  endtask

  task automatic t_mode0;
    wr(16'h5100, 8'hFC);    // upper bits junk, mode 0
    wr(16'h5117, 8'h2F);
    probe(16'h8000, 1'b0, "R4");
    probe(16'hA123, 1'b0, "R4");
    probe(16'hC000, 1'b0, "R4");
    probe(16'hFFFF, 1'b1, "R4");
  endtask

  task automatic t_mode1;
    wr(16'h5100, 8'h01);
    wr(16'h5115, 8'h87); wr(16'h5117, 8'h13);
    probe(16'h8001, 1'b0, "R5");
    probe(16'hA002, 1'b0, "R5");
    probe(16'hC003, 1'b0, "R5");
    probe(16'hE004, 1'b0, "R5");
    wr(16'h5115, 8'h05);    // RAM, chip 1
    probe(16'h8100, 1'b0, "R5 R8");
    probe(16'hB100, 1'b0, "R5 R8");
  endtask

  task automatic t_mode2;
    wr(16'h5100, 8'h02);
    wr(16'h5115, 8'h9B); wr(16'h5116, 8'hC5); wr(16'h5117, 8'h33);
    probe(16'h8010, 1'b0, "R6");
    probe(16'hA020, 1'b0, "R6");
    probe(16'hC030, 1'b0, "R6");
    probe(16'hE040, 1'b0, "R6");
    wr(16'h5116, 8'h06);
    probe(16'hD000, 1'b0, "R6 R8");
  endtask

  task automatic t_ram_sel;
    wr(16'h5100, 8'h03);
    wr(16'h5113, 8'hFD);    // chip 1 bank 1
    probe(16'h6ABC, 1'b0, "R3");
    wr(16'h5113, 8'h02);
    probe(16'h7001, 1'b0, "R3");
    wr(16'h5114, 8'h07); wr(16'h5115, 8'h02); wr(16'h5116, 8'h7D);
    wr(16'h5117, 8'h15);    // bit 7 clear, still ROM
    probe(16'h8000, 1'b0, "R8");
    probe(16'hA000, 1'b0, "R8");
    probe(16'hC000, 1'b0, "R8");
    probe(16'hE000, 1'b0, "R8 last ROM");
  endtask

  task automatic t_protect;
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        wr(16'h5102, 8'(a)); wr(16'h5103, 8'(b));
        probe(16'h6000, 1'b1, "R9");
      end
    end
    wr(16'h5102, 8'hFE); wr(16'h5103, 8'hA5);
    probe(16'h6F00, 1'b1, "R9 low bits only");
    probe(16'h8000, 1'b1, "R9 middle RAM");
    probe(16'h6F00, 1'b0, "R9 no strobe");
  endtask

  task automatic t_rom_write;
    wr(16'h5114, 8'h90);
    probe(16'h8000, 1'b1, "R10");
    probe(16'hE000, 1'b1, "R10");
    wr(16'h5100, 8'h00);
    probe(16'hC000, 1'b1, "R10");
  endtask

  task automatic t_low;
    probe(16'h0000, 1'b0, "R11");
    probe(16'h4020, 1'b0, "R11");
    probe(16'h5FFF, 1'b0, "R11");
    probe(16'h2000, 1'b1, "R11");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_mode3();
    t_decode();
    t_mode0();
    t_mode1();
    t_mode2();
    t_ram_sel();
    t_protect();
    t_rom_write();
    t_low();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule